// File: doc/BRIEF.md
# Sticky GPIO Interrupt Controller

This block gathers a handful of external pin inputs and a set of internal event signals into one 16-bit status word, and turns that word into an interrupt line and a wake request. External pins cross into the clock domain through a two-stage synchroniser. Internal sources arrive already synchronous: two battery comparators, pen-down, conversion-data-ready, and a thermal-OK flag that drops on over-temperature. Internal sources can only be read. No output path exists for them.

Each bit has its own polarity, sticky and wake enable, plus an interrupt enable. A sticky bit latches on the active edge of its source and holds until software writes a 0 to it. A non-sticky bit follows the source level. The second battery comparator can pass through a qualification delay. If its condition goes away before the delay runs out, nothing is recorded. Once per link frame, a snapshot of the status word is offered on a valid/ready output for transmission in a frame slot.

The slot output follows valid/ready rules. `slot_tick` loads a snapshot only when no snapshot is pending, or when the pending one is accepted in the same cycle. While `slot_valid` is high and `slot_ready` is low, `slot_data` is held stable and further ticks are dropped.

Top module: `gpirq_top`

## Requirements
- R1: While `rst_n` is low, `status_o`, `irq_o`, `wake_o` and `slot_valid` are all 0.
- R2: `pin_in[j]` drives status bit 1+j. A change on the pin reaches that bit after the third rising clock edge that samples it, and not after the second.
- R3: `cfg_pol[i]`=1 makes a source active when high. `cfg_pol[i]`=0 makes it active when low. This applies to internal sources as well as pins.
- R4: When `cfg_sticky[i]`=1, bit i sets on the inactive-to-active transition of its source and stays set after the source returns inactive.
- R5: An edge with `clr_valid`=1 clears every sticky bit whose `clr_mask` bit is 0. Bits whose mask bit is 1 are unchanged. Non-sticky bits keep following their source.
- R6: If a clear and a new active transition reach the same sticky bit on the same edge, the bit ends up set.
- R7: `irq_o` is 1 exactly when some bit is set with both `cfg_sticky` and `cfg_irq_en` at 1. Set non-sticky bits never raise it.
- R8: `wake_o` is 1 exactly when some set bit has `cfg_wake_en` at 1.
- R9: With `cfg_dly_en`=1 and `cfg_dly_cyc`=D, bit 14 becomes active only after its source has been active on D+1 consecutive rising edges. It is visible after the last of those edges. A shorter activity leaves no trace.
- R10: With `cfg_dly_en`=0, bit 14 behaves like any other internal source, with one edge of latency.
- R11: Status bits 0 and 6 to 10 always read 0.
- R12: A `slot_tick` accepted as described above loads `slot_data` with the status word seen before that edge and raises `slot_valid`. Data stays stable until `slot_valid` and `slot_ready` are both high on an edge, which clears `slot_valid`.
- R13: The bit map is fixed. First comparator is bit 15, second comparator bit 14, pen-down bit 13, data-ready bit 12, thermal-OK bit 11. Bit 11 is the inverse of `over_temp_in`, so it deasserts on over-temperature. Each internal source reaches its bit after one edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | NPIN | Asynchronous external pin inputs |
| comp1_in | input | 1 | First battery comparator |
| comp2_in | input | 1 | Second battery comparator |
| pen_down_in | input | 1 | Pen-down detect |
| data_rdy_in | input | 1 | Conversion data ready |
| over_temp_in | input | 1 | Over-temperature flag |
| cfg_pol | input | 16 | Per-bit active-high select |
| cfg_sticky | input | 16 | Per-bit sticky select |
| cfg_irq_en | input | 16 | Per-bit interrupt enable |
| cfg_wake_en | input | 16 | Per-bit wake enable |
| cfg_dly_en | input | 1 | Enable delay on bit 14 |
| cfg_dly_cyc | input | DLY_W | Delay length in cycles |
| clr_valid | input | 1 | Software clear write strobe |
| clr_mask | input | 16 | Clear data, 0 clears a sticky bit |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wake request |
| slot_tick | input | 1 | Frame slot snapshot request |
| slot_ready | input | 1 | Slot consumer ready |
| slot_valid | output | 1 | Snapshot valid |
| slot_data | output | 16 | Snapshot of the status word |

## Verification
The collision that matters is a software clear landing on the same edge as a fresh active transition of a sticky bit. The bench first latches the first comparator and drops it. It then raises the comparator again in the very cycle that carries a clear for that bit, and requires the bit to read 1 afterwards. A second clear with no new edge must then read 0. The slot output has a similar overlap: a tick arrives while an unaccepted snapshot is still pending. The bench changes the status word in between and checks that the pending snapshot keeps its old value.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int SW        = 16;
  localparam int PIN_LSB   = 1;
  localparam int BIT_THERM = 11;
  localparam int BIT_DRDY  = 12;
  localparam int BIT_PEN   = 13;
  localparam int BIT_COMP2 = 14;
  localparam int BIT_COMP1 = 15;

  // Bits that have a source behind them.
  function automatic logic [SW-1:0] map_mask(int npin);
    logic [SW-1:0] m;
    m = '0;
    for (int i = 0; i < npin; i++) m[PIN_LSB+i] = 1'b1;
    m[BIT_THERM] = 1'b1;
    m[BIT_DRDY]  = 1'b1;
    m[BIT_PEN]   = 1'b1;
    m[BIT_COMP2] = 1'b1;
    m[BIT_COMP1] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/gpirq_sync.sv
module gpirq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1, s2;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d_i;
      s2 <= s1;
    end
  end
  assign q_o = s2;
endmodule

// File: rtl/gpirq_delay.sv
module gpirq_delay #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [CW-1:0] lim_i,
  input  logic          act_i,
  output logic          qual_o
);
  logic [CW-1:0] cnt;
  // Count consecutive active cycles, saturating at the limit.
  always_ff @(posedge clk) begin
    if (!rst_n || !act_i) cnt <= '0;
    else if (cnt < lim_i) cnt <= cnt + 1'b1;
  end
  assign qual_o = act_i && (!en_i || (cnt >= lim_i));
endmodule

// File: rtl/gpirq_cell.sv
module gpirq_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic sticky_i,
  input  logic clr_i,
  output logic st_o
);
  logic prev, st;
  logic rise;
  assign rise = lvl_i && !prev;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev <= 1'b0;
      st   <= 1'b0;
    end else begin
      prev <= lvl_i;
      if (sticky_i) st <= (st && !clr_i) || rise;
      else          st <= lvl_i;
    end
  end
  assign st_o = st;
endmodule

// File: rtl/gpirq_top.sv
module gpirq_top
  import gpirq_pkg::*;
#(
  parameter int NPIN  = 5,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pin_in,
  input  logic             comp1_in,
  input  logic             comp2_in,
  input  logic             pen_down_in,
  input  logic             data_rdy_in,
  input  logic             over_temp_in,
  input  logic [SW-1:0]    cfg_pol,
  input  logic [SW-1:0]    cfg_sticky,
  input  logic [SW-1:0]    cfg_irq_en,
  input  logic [SW-1:0]    cfg_wake_en,
  input  logic             cfg_dly_en,
  input  logic [DLY_W-1:0] cfg_dly_cyc,
  input  logic             clr_valid,
  input  logic [SW-1:0]    clr_mask,
  output logic [SW-1:0]    status_o,
  output logic             irq_o,
  output logic             wake_o,
  input  logic             slot_tick,
  input  logic             slot_ready,
  output logic             slot_valid,
  output logic [SW-1:0]    slot_data
);
  localparam logic [SW-1:0] MAP = map_mask(NPIN);

  logic [NPIN-1:0] pin_s;
  logic [SW-1:0]   raw, act, lvl, clr_vec, st;
  logic            comp2_q;

  gpirq_sync #(.W(NPIN)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (pin_in),
    .q_o   (pin_s)
  );

  always_comb begin
    raw = '0;
    raw[PIN_LSB +: NPIN] = pin_s;
    raw[BIT_COMP1] = comp1_in;
    raw[BIT_COMP2] = comp2_in;
    raw[BIT_PEN]   = pen_down_in;
    raw[BIT_DRDY]  = data_rdy_in;
    raw[BIT_THERM] = !over_temp_in;
  end

  assign act = ~(raw ^ cfg_pol);

  gpirq_delay #(.CW(DLY_W)) u_dly (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (cfg_dly_en),
    .lim_i  (cfg_dly_cyc),
    .act_i  (act[BIT_COMP2]),
    .qual_o (comp2_q)
  );

  always_comb begin
    lvl = act & MAP;
    lvl[BIT_COMP2] = comp2_q;
  end

  assign clr_vec = clr_valid ? ~clr_mask : '0;

  for (genvar gi = 0; gi < SW; gi++) begin : g_bit
    gpirq_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_i    (lvl[gi]),
      .sticky_i (cfg_sticky[gi]),
      .clr_i    (clr_vec[gi]),
      .st_o     (st[gi])
    );
  end

  assign status_o = st;
  assign irq_o    = |(st & cfg_sticky & cfg_irq_en);
  assign wake_o   = |(st & cfg_wake_en);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_valid <= 1'b0;
      slot_data  <= '0;
    end else if (slot_tick && (!slot_valid || slot_ready)) begin
      slot_valid <= 1'b1;
      slot_data  <= st;
    end else if (slot_ready) begin
      slot_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/gpirq_chk.sv
module gpirq_chk
  import gpirq_pkg::*;
#(
  parameter int NPIN  = 5,
  parameter int DLY_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             comp2_in,
  input logic             pol14,
  input logic [SW-1:0]    cfg_sticky,
  input logic [SW-1:0]    cfg_irq_en,
  input logic [SW-1:0]    cfg_wake_en,
  input logic             cfg_dly_en,
  input logic [DLY_W-1:0] cfg_dly_cyc,
  input logic             clr_valid,
  input logic [SW-1:0]    clr_mask,
  input logic [SW-1:0]    status_o,
  input logic             irq_o,
  input logic             wake_o,
  input logic             slot_ready,
  input logic             slot_valid,
  input logic [SW-1:0]    slot_data
);
  localparam logic [SW-1:0] MAP = map_mask(NPIN);

  logic [DLY_W:0] run;
  logic           act14;
  assign act14 = !(comp2_in ^ pol14);
  always_ff @(posedge clk) begin
    if (!rst_n || !act14) run <= '0;
    else if (run != '1) run <= run + 1'b1;
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & ~MAP) == '0); // R11

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !slot_ready) |=> (slot_valid && $stable(slot_data))); // R12

  AST_NO_IRQ_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_irq_en == '0) |-> !irq_o); // R7

  AST_NO_WAKE_UNENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wake_en == '0) |-> !wake_o); // R8

  AST_COMP2_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(status_o[BIT_COMP2]) && $past(cfg_dly_en))
      |-> (run > {1'b0, $past(cfg_dly_cyc)})); // R9

  for (genvar gi = 0; gi < SW; gi++) begin : g_hold
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[gi] && cfg_sticky[gi] && !(clr_valid && !clr_mask[gi]))
        |=> status_o[gi]); // R4
  end
endmodule

bind gpirq_top gpirq_chk #(.NPIN(NPIN), .DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .comp2_in    (comp2_in),
  .pol14       (cfg_pol[14]),
  .cfg_sticky  (cfg_sticky),
  .cfg_irq_en  (cfg_irq_en),
  .cfg_wake_en (cfg_wake_en),
  .cfg_dly_en  (cfg_dly_en),
  .cfg_dly_cyc (cfg_dly_cyc),
  .clr_valid   (clr_valid),
  .clr_mask    (clr_mask),
  .status_o    (status_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o),
  .slot_ready  (slot_ready),
  .slot_valid  (slot_valid),
  .slot_data   (slot_data)
);

// File: tb/gpirq_top_tb.sv
module gpirq_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  pin_in;
  logic        comp1_in, comp2_in, pen_down_in, data_rdy_in, over_temp_in;
  logic [15:0] cfg_pol, cfg_sticky, cfg_irq_en, cfg_wake_en;
  logic        cfg_dly_en;
  logic [7:0]  cfg_dly_cyc;
  logic        clr_valid;
  logic [15:0] clr_mask;
  logic [15:0] status_o;
  logic        irq_o, wake_o;
  logic        slot_tick, slot_ready, slot_valid;
  logic [15:0] slot_data;

  always #10 clk = ~clk;

  gpirq_top #(.NPIN(5), .DLY_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .comp1_in(comp1_in), .comp2_in(comp2_in), .pen_down_in(pen_down_in),
    .data_rdy_in(data_rdy_in), .over_temp_in(over_temp_in),
    .cfg_pol(cfg_pol), .cfg_sticky(cfg_sticky), .cfg_irq_en(cfg_irq_en),
    .cfg_wake_en(cfg_wake_en), .cfg_dly_en(cfg_dly_en), .cfg_dly_cyc(cfg_dly_cyc),
    .clr_valid(clr_valid), .clr_mask(clr_mask),
    .status_o(status_o), .irq_o(irq_o), .wake_o(wake_o),
    .slot_tick(slot_tick), .slot_ready(slot_ready),
    .slot_valid(slot_valid), .slot_data(slot_data)
  );

  typedef struct {
    int          cyc;
    string       req;
    int          kind;
    logic [15:0] mask;
    logic [15:0] val;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] observe(int kind);
    case (kind)
      0: return status_o;
      1: return {15'b0, irq_o};
      2: return {15'b0, wake_o};
      3: return {15'b0, slot_valid};
      default: return slot_data;
    endcase
  endfunction

  task automatic compare(string req, int kind, logic [15:0] mask, logic [15:0] val);
    logic [15:0] a;
    a = observe(kind);
    n_run++;
    if ((a & mask) !== (val & mask)) begin
      n_fail++;
      $display("FAIL %s kind=%0d cyc=%0d actual=%h expected=%h mask=%h",
               req, kind, cyc, a & mask, val & mask, mask);
    end
  endtask

  task automatic push(string req, int kind, logic [15:0] mask, logic [15:0] val, int lat);
    q.push_back('{cyc + lat, req, kind, mask, val});
  endtask

  task automatic settle();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic clear_bits(logic [15:0] m);
    @(negedge clk);
    clr_valid = 1'b1;
    clr_mask  = ~m;
    @(negedge clk);
    clr_valid = 1'b0;
    clr_mask  = '1;
  endtask

  // Monitor: compare scheduled expectations as their cycle arrives.
  always @(negedge clk) begin
    while (q.size() != 0 && q[0].cyc <= cyc) begin
      exp_t it;
      it = q.pop_front();
      compare(it.req, it.kind, it.mask, it.val);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pin_in = '0;
    comp1_in = 0; comp2_in = 0; pen_down_in = 0; data_rdy_in = 0; over_temp_in = 0;
    cfg_pol = 16'hFFFF; cfg_sticky = 16'hF006; cfg_irq_en = 16'hF006; cfg_wake_en = '0;
    cfg_dly_en = 1; cfg_dly_cyc = 8'd4;
    clr_valid = 0; clr_mask = '1; slot_tick = 0; slot_ready = 0;
    repeat (3) @(negedge clk);
    compare("R1", 0, 16'hFFFF, 16'h0000);
    compare("R1", 1, 16'h0001, 16'h0000);
    compare("R1", 2, 16'h0001, 16'h0000);
    compare("R1", 3, 16'h0001, 16'h0000);
    rst_n = 1;
    push("R13", 0, 16'h0800, 16'h0800, 1);
    settle();

    // R13 thermal bit deasserts on over-temperature; R3 polarity
    @(negedge clk); over_temp_in = 1; push("R13", 0, 16'h0800, 16'h0000, 1); settle();
    @(negedge clk); cfg_pol[11] = 0;  push("R3", 0, 16'h0800, 16'h0800, 1); settle();
    @(negedge clk); cfg_pol[11] = 1; over_temp_in = 0;
    push("R3", 0, 16'h0800, 16'h0800, 1); settle();

    // R2 synchroniser latency on a non-sticky pin (pin 2 -> bit 3)
    @(negedge clk); pin_in[2] = 1;
    push("R2", 0, 16'h0008, 16'h0000, 2);
    push("R2", 0, 16'h0008, 16'h0008, 3);
    settle();
    @(negedge clk); pin_in[2] = 0; push("R2", 0, 16'h0008, 16'h0000, 3); settle();

    // R4 sticky pin 0 -> bit 1 survives the pulse; R7 irq
    @(negedge clk); pin_in[0] = 1; push("R4", 0, 16'h0002, 16'h0002, 3);
    @(negedge clk); pin_in[0] = 0;
    push("R4", 0, 16'h0002, 16'h0002, 5);
    push("R7", 1, 16'h0001, 16'h0001, 5);
    settle();

    // R5 mask bit 1 keeps, mask bit 0 clears
    @(negedge clk); clr_valid = 1; clr_mask = 16'hFFFF; push("R5", 0, 16'h0002, 16'h0002, 2);
    @(negedge clk); clr_valid = 0; settle();
    @(negedge clk); clr_valid = 1; clr_mask = ~16'h0002;
    push("R5", 0, 16'h0002, 16'h0000, 1);
    push("R7", 1, 16'h0001, 16'h0000, 1);
    @(negedge clk); clr_valid = 0; clr_mask = '1; settle();

    // R5 non-sticky bit ignores a clear
    @(negedge clk); pin_in[2] = 1;
    repeat (3) @(negedge clk);
    clr_valid = 1; clr_mask = 16'h0000; push("R5", 0, 16'h0008, 16'h0008, 1);
    @(negedge clk); clr_valid = 0; clr_mask = '1; settle();

    // R7 a set non-sticky enabled bit does not raise irq
    @(negedge clk); cfg_irq_en = 16'hF00E;
    push("R7", 1, 16'h0001, 16'h0000, 1);
    push("R7", 0, 16'h0008, 16'h0008, 1);
    settle();

    // R8 wake follows enabled set bits
    @(negedge clk); cfg_wake_en = 16'h0008; push("R8", 2, 16'h0001, 16'h0001, 1); settle();
    @(negedge clk); cfg_wake_en = 16'h0000; push("R8", 2, 16'h0001, 16'h0000, 1); settle();
    @(negedge clk); pin_in[2] = 0; repeat (4) @(negedge clk);

    // R6 clear and new edge on the same cycle: set wins
    @(negedge clk); comp1_in = 1;
    push("R13", 0, 16'h8000, 16'h8000, 1);
    push("R7", 1, 16'h0001, 16'h0001, 1);
    settle();
    @(negedge clk); comp1_in = 0; push("R4", 0, 16'h8000, 16'h8000, 1); settle();
    @(negedge clk); comp1_in = 1; clr_valid = 1; clr_mask = ~16'h8000;
    push("R6", 0, 16'h8000, 16'h8000, 1);
    @(negedge clk); clr_valid = 0; clr_mask = '1; settle();
    @(negedge clk); clr_valid = 1; clr_mask = ~16'h8000;
    push("R5", 0, 16'h8000, 16'h0000, 1);
    push("R7", 1, 16'h0001, 16'h0000, 1);
    @(negedge clk); clr_valid = 0; clr_mask = '1; comp1_in = 0; settle();

    // R9 comp2 active on only D edges: never recorded
    @(negedge clk); comp2_in = 1;
    push("R9", 0, 16'h4000, 16'h0000, 5);
    push("R9", 0, 16'h4000, 16'h0000, 7);
    repeat (4) @(negedge clk); comp2_in = 0;
    settle();
    // R9 comp2 active on D+1 edges: recorded after the last one
    @(negedge clk); comp2_in = 1;
    push("R9", 0, 16'h4000, 16'h0000, 4);
    push("R9", 0, 16'h4000, 16'h4000, 5);
    repeat (5) @(negedge clk); comp2_in = 0;
    settle();
    clear_bits(16'h4000); push("R5", 0, 16'h4000, 16'h0000, 0); settle();

    // R10 delay disabled
    @(negedge clk); cfg_dly_en = 0; comp2_in = 1; push("R10", 0, 16'h4000, 16'h4000, 1);
    @(negedge clk); comp2_in = 0; settle();
    clear_bits(16'h4000);
    @(negedge clk); cfg_dly_en = 1;

    // R13 pen-down and data-ready mapping
    @(negedge clk); pen_down_in = 1; data_rdy_in = 1; push("R13", 0, 16'h3000, 16'h3000, 1);
    @(negedge clk); pen_down_in = 0; data_rdy_in = 0; push("R4", 0, 16'h3000, 16'h3000, 1);
    settle();
    clear_bits(16'h3000); push("R5", 0, 16'h3000, 16'h0000, 0); settle();

    // R11 unmapped bits stay zero with all pins high
    @(negedge clk); pin_in = '1;
    push("R11", 0, 16'h07C1, 16'h0000, 3);
    push("R2", 0, 16'h003E, 16'h003E, 3);
    settle();
    @(negedge clk); pin_in = '0; repeat (4) @(negedge clk);
    clear_bits(16'hFFFF);
    @(negedge clk); push("R11", 0, 16'hFFFF, 16'h0800, 1); settle();

    // R12 slot snapshot with back-pressure
    @(negedge clk); slot_tick = 1;
    push("R12", 3, 16'h0001, 16'h0001, 1);
    push("R12", 4, 16'hFFFF, 16'h0800, 1);
    @(negedge clk); slot_tick = 0; pen_down_in = 1;
    repeat (2) @(negedge clk);
    slot_tick = 1;
    push("R12", 3, 16'h0001, 16'h0001, 1);
    push("R12", 4, 16'hFFFF, 16'h0800, 1);
    @(negedge clk); slot_tick = 0; settle();
    @(negedge clk); slot_ready = 1; push("R12", 3, 16'h0001, 16'h0000, 1);
    @(negedge clk); slot_ready = 0; settle();
    @(negedge clk); slot_tick = 1;
    push("R12", 3, 16'h0001, 16'h0001, 1);
    push("R12", 4, 16'hFFFF, 16'h2800, 1);
    @(negedge clk); slot_tick = 0; pen_down_in = 0; settle();

    repeat (2) @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule